// File: doc/BRIEF.md
# I2C Bus Idle Timeout and Stop Monitor

This block sits next to an I2C controller on a bus shared by several masters. It samples the already synchronized SCL and SDA lines and counts prescaled clock ticks during which neither line moves. If the count reaches a selectable limit, it raises a sticky timeout flag. This lets software recover from a bus that a faulty device holds stuck.

The block also detects stop conditions. When the stop interrupt is enabled, each stop condition sets a sticky stop flag that only hardware can set.

Software controls the block through two write ports:
- A configuration port carries three controls: timeout enable, long/short window select and stop-interrupt enable.
- A status port clears either flag by writing 0 to that flag's bit.

The interrupt request is the OR of the two flags.

Top module: `i2c_idle_watch`

## Requirements
- R1: While the timeout enable is 0, the idle counter holds at zero and the timeout flag is never set. Clearing the enable also drops any saturated state.
- R2: With the window select at 0 (long), the timeout flag is set on the clock edge of the 2**LONG_W-th tick after the last bus activity (65536 by default). No earlier tick sets it.
- R3: With the window select at 1 (short), the timeout flag is set on the edge of the 2**SHORT_W-th tick after the last bus activity (16384 by default).
- R4: A configuration write changes the window select only if the stored timeout enable is 0 when the write occurs. Otherwise the select keeps its value, and the enable and stop-interrupt fields of that same write still take effect.
- R5: Any change of SCL or SDA between two consecutive clocks restarts the idle count from zero, and a cycle with activity counts no tick. Cycles with tick_en low do not advance the count.
- R6: After a timeout the counter saturates. Further idle ticks produce no new event until bus activity occurs or the timeout is disabled. The timeout flag stays set until software clears it.
- R7: A stop condition is a rising edge of SDA while SCL is high in both the previous and the current sample. It sets the stop flag only while the stop-interrupt enable is 1. An SDA rise while SCL is low, or an SDA fall, sets nothing.
- R8: A status write clears the timeout flag when stat_wdata[0] is 0 and clears the stop flag when stat_wdata[1] is 0. A 1 in a bit leaves that flag unchanged, so software cannot set a flag.
- R9: If a hardware set and a software clear of the same flag fall in the same cycle, the flag ends up set.
- R10: irq equals the OR of the timeout flag and the stop flag, updated on the same edge as the flags.
- R11: Synchronous reset clears both flags, irq, the timeout enable, the window select and the stop-interrupt enable. It also takes both previous line samples to 1, which is the idle bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | One-cycle prescaled tick |
| scl_in | input | 1 | Synchronized SCL level |
| sda_in | input | 1 | Synchronized SDA level |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_to_en | input | 1 | Timeout enable value written |
| cfg_short | input | 1 | Window select value written (1 = short) |
| cfg_stop_ie | input | 1 | Stop-interrupt enable value written |
| stat_we | input | 1 | Status write strobe |
| stat_wdata | input | 2 | Status write data: bit 0 timeout flag, bit 1 stop flag, 0 clears |
| to_flag | output | 1 | Sticky timeout flag |
| stop_flag | output | 1 | Sticky stop-condition flag |
| irq | output | 1 | Interrupt request |

## Verification
The bench drives exact tick counts to both window limits and checks that the flag is still low one tick before each limit. A counter that is off by one, or that uses the wrong width, fails this check.

It tries to change the window select while the timeout is enabled and then restarts the count with activity. A design that accepted the write would fire at the long limit instead of the short one. It also keeps ticking after a timeout has been cleared, which catches a counter that wraps and fires again.

For the stop flag, the bench checks the following cases:
- SDA rises while SCL is low, and a stop occurs while the interrupt is disabled. A decoder that is too loose sets the flag in these cases.
- A write of 1 to the flag bit. A design that lets software set the flag shows it here.
- A stop that coincides with a clear. A design with the wrong priority loses the flag.

// File: rtl/i2c_watch_pkg.sv
package i2c_watch_pkg;
  // Control fields held by the configuration register
  typedef struct packed {
    logic to_en;
    logic to_short;
    logic stop_ie;
  } watch_cfg_t;

  // Bit positions of the flags on the status write port
  localparam int unsigned FLAG_TO   = 0;
  localparam int unsigned FLAG_STOP = 1;
  localparam int unsigned NFLAG     = 2;
endpackage

// File: rtl/line_monitor.sv
module line_monitor (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  output logic activity,
  output logic stop_det
);
  logic scl_d;
  logic sda_d;

  // Previous samples; the idle bus has both lines high
  always_ff @(posedge clk) begin
    if (rst) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_in;
      sda_d <= sda_in;
    end
  end

  assign activity = (scl_d ^ scl_in) | (sda_d ^ sda_in);
  assign stop_det = scl_d & scl_in & ~sda_d & sda_in;
endmodule

// File: rtl/idle_timer.sv
module idle_timer #(
  parameter int unsigned LONG_W  = 16,
  parameter int unsigned SHORT_W = 14
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_en,
  input  logic en,
  input  logic short_sel,
  input  logic activity,
  output logic to_evt
);
  localparam int unsigned PAD_W = LONG_W - SHORT_W;
  localparam logic [LONG_W-1:0] LONG_LAST  = {LONG_W{1'b1}};
  localparam logic [LONG_W-1:0] SHORT_LAST = {{PAD_W{1'b0}}, {SHORT_W{1'b1}}};

  logic [LONG_W-1:0] cnt_q;
  logic              sat_q;
  logic [LONG_W-1:0] last;
  logic              at_last;

  assign last    = short_sel ? SHORT_LAST : LONG_LAST;
  assign at_last = (cnt_q == last);
  assign to_evt  = en & ~activity & tick_en & ~sat_q & at_last;

  always_ff @(posedge clk) begin
    if (rst || !en || activity) begin
      cnt_q <= '0;
      sat_q <= 1'b0;
    end else if (tick_en && !sat_q) begin
      if (at_last) sat_q <= 1'b1;
      else         cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/watch_regs.sv
module watch_regs
  import i2c_watch_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  watch_cfg_t       cfg_wdata,
  input  logic             stat_we,
  input  logic [NFLAG-1:0] stat_wdata,
  input  logic             to_evt,
  input  logic             stop_det,
  output watch_cfg_t       cfg_q,
  output logic [NFLAG-1:0] flags_q,
  output logic             irq_q
);
  logic [NFLAG-1:0] set_v;
  logic [NFLAG-1:0] flags_nxt;

  assign set_v[FLAG_TO]   = to_evt;
  assign set_v[FLAG_STOP] = stop_det & cfg_q.stop_ie;

  // The window select is writable only while the timeout is disabled
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
    end else if (cfg_we) begin
      cfg_q.to_en   <= cfg_wdata.to_en;
      cfg_q.stop_ie <= cfg_wdata.stop_ie;
      if (!cfg_q.to_en) cfg_q.to_short <= cfg_wdata.to_short;
    end
  end

  // Write-zero-to-clear; a hardware set overrides a clear
  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    assign flags_nxt[i] = set_v[i] | (flags_q[i] & ~(stat_we & ~stat_wdata[i]));
    always_ff @(posedge clk) begin
      if (rst) flags_q[i] <= 1'b0;
      else     flags_q[i] <= flags_nxt[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |flags_nxt;
  end
endmodule

// File: rtl/i2c_idle_watch.sv
module i2c_idle_watch
  import i2c_watch_pkg::*;
#(
  parameter int unsigned LONG_W  = 16,
  parameter int unsigned SHORT_W = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_en,
  input  logic             scl_in,
  input  logic             sda_in,
  input  logic             cfg_we,
  input  logic             cfg_to_en,
  input  logic             cfg_short,
  input  logic             cfg_stop_ie,
  input  logic             stat_we,
  input  logic [NFLAG-1:0] stat_wdata,
  output logic             to_flag,
  output logic             stop_flag,
  output logic             irq
);
  watch_cfg_t       cfg_wdata;
  watch_cfg_t       cfg_q;
  logic [NFLAG-1:0] flags_q;
  logic             activity;
  logic             stop_det;
  logic             to_evt;
  logic             en_q;
  logic             short_q;
  logic             stop_ie_q;

  assign cfg_wdata = '{to_en: cfg_to_en, to_short: cfg_short, stop_ie: cfg_stop_ie};
  assign en_q      = cfg_q.to_en;
  assign short_q   = cfg_q.to_short;
  assign stop_ie_q = cfg_q.stop_ie;

  line_monitor u_lines (
    .clk      (clk),
    .rst      (rst),
    .scl_in   (scl_in),
    .sda_in   (sda_in),
    .activity (activity),
    .stop_det (stop_det)
  );

  idle_timer #(.LONG_W(LONG_W), .SHORT_W(SHORT_W)) u_timer (
    .clk       (clk),
    .rst       (rst),
    .tick_en   (tick_en),
    .en        (en_q),
    .short_sel (short_q),
    .activity  (activity),
    .to_evt    (to_evt)
  );

  watch_regs u_regs (
    .clk        (clk),
    .rst        (rst),
    .cfg_we     (cfg_we),
    .cfg_wdata  (cfg_wdata),
    .stat_we    (stat_we),
    .stat_wdata (stat_wdata),
    .to_evt     (to_evt),
    .stop_det   (stop_det),
    .cfg_q      (cfg_q),
    .flags_q    (flags_q),
    .irq_q      (irq)
  );

  assign to_flag   = flags_q[FLAG_TO];
  assign stop_flag = flags_q[FLAG_STOP];
endmodule

// File: rtl/watch_checker.sv
module watch_checker (
  input logic clk,
  input logic rst,
  input logic en_q,
  input logic short_q,
  input logic stop_ie_q,
  input logic to_evt,
  input logic stop_det,
  input logic to_flag,
  input logic stop_flag,
  input logic irq
);
  assert_disabled_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    !en_q |-> !to_evt);

  assert_select_locked_R4: assert property (@(posedge clk) disable iff (rst)
    $past(en_q) |-> $stable(short_q));

  assert_no_repeat_R6: assert property (@(posedge clk) disable iff (rst)
    $past(to_evt) |-> !to_evt);

  assert_stop_source_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(stop_flag) |-> $past(stop_det && stop_ie_q));

  assert_timeout_source_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(to_flag) |-> $past(to_evt));

  assert_irq_or_R10: assert property (@(posedge clk) disable iff (rst)
    irq == (to_flag | stop_flag));
endmodule

bind i2c_idle_watch watch_checker u_chk (
  .clk       (clk),
  .rst       (rst),
  .en_q      (en_q),
  .short_q   (short_q),
  .stop_ie_q (stop_ie_q),
  .to_evt    (to_evt),
  .stop_det  (stop_det),
  .to_flag   (to_flag),
  .stop_flag (stop_flag),
  .irq       (irq)
);

// File: tb/sim_i2c_idle_watch.sv
`timescale 1ns/1ps
module sim_i2c_idle_watch;
  localparam int LW = 10;
  localparam int SW = 8;
  localparam int NL = 1 << LW;
  localparam int NS = 1 << SW;

  typedef struct {
    string tag;
    logic  to;
    logic  st;
    logic  ir;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_en = 1'b0, scl_in = 1'b1, sda_in = 1'b1;
  logic cfg_we = 1'b0, cfg_to_en = 1'b0, cfg_short = 1'b0, cfg_stop_ie = 1'b0;
  logic stat_we = 1'b0;
  logic [1:0] stat_wdata = 2'b11;
  logic to_flag, stop_flag, irq;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  exp_t q[$];

  always #10 clk = ~clk;

  i2c_idle_watch #(.LONG_W(LW), .SHORT_W(SW)) u0 (
    .clk(clk), .rst(rst), .tick_en(tick_en), .scl_in(scl_in), .sda_in(sda_in),
    .cfg_we(cfg_we), .cfg_to_en(cfg_to_en), .cfg_short(cfg_short),
    .cfg_stop_ie(cfg_stop_ie), .stat_we(stat_we), .stat_wdata(stat_wdata),
    .to_flag(to_flag), .stop_flag(stop_flag), .irq(irq)
  );

  // Monitor: compares one expectation after the edge that follows its push
  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      total++;
      if (to_flag !== e.to || stop_flag !== e.st || irq !== e.ir) begin
        bad++;
        $display("FAIL %s: got to=%b stop=%b irq=%b expected to=%b stop=%b irq=%b",
                 e.tag, to_flag, stop_flag, irq, e.to, e.st, e.ir);
      end
    end
  end

  task automatic clear_pulses();
    cfg_we = 1'b0; stat_we = 1'b0; tick_en = 1'b0; stat_wdata = 2'b11;
  endtask

  task automatic tick_n(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); clear_pulses(); tick_en = 1'b1;
    end
  endtask

  task automatic cfg_wr(input logic en, input logic sh, input logic ie);
    @(negedge clk); clear_pulses();
    cfg_we = 1'b1; cfg_to_en = en; cfg_short = sh; cfg_stop_ie = ie;
  endtask

  task automatic stat_wr(input logic [1:0] d);
    @(negedge clk); clear_pulses(); stat_we = 1'b1; stat_wdata = d;
  endtask

  task automatic lines(input logic scl, input logic sda);
    @(negedge clk); clear_pulses(); scl_in = scl; sda_in = sda;
  endtask

  task automatic expect_now(input string tag, input logic to, input logic st, input logic ir);
    exp_t e;
    @(negedge clk); clear_pulses();
    e.tag = tag; e.to = to; e.st = st; e.ir = ir;
    q.push_back(e);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    expect_now("R11 reset", 0, 0, 0);

    tick_n(NL + 10);
    expect_now("R1 disabled no timeout", 0, 0, 0);

    cfg_wr(0, 1, 0);
    cfg_wr(1, 1, 0);
    tick_n(NS - 1);
    expect_now("R3 short one tick early", 0, 0, 0);
    tick_n(1);
    expect_now("R3 short fires / R10 irq", 1, 0, 1);

    tick_n(NS + 5);
    expect_now("R6 flag sticky", 1, 0, 1);
    stat_wr(2'b01);
    expect_now("R8 write 1 keeps timeout", 1, 0, 1);
    stat_wr(2'b10);
    expect_now("R8 write 0 clears timeout", 0, 0, 0);
    tick_n(NS + 5);
    expect_now("R6 no repeat event", 0, 0, 0);

    cfg_wr(1, 0, 0);
    lines(0, 1);
    lines(1, 1);
    tick_n(NS - 1);
    expect_now("R4 select ignored early", 0, 0, 0);
    tick_n(1);
    expect_now("R4 select ignored still short", 1, 0, 1);

    stat_wr(2'b10);
    tick_n(100);
    lines(0, 1);
    tick_n(NS - 1);
    expect_now("R5 activity restarts count", 0, 0, 0);
    tick_n(1);
    expect_now("R5 fires after restart", 1, 0, 1);
    lines(1, 1);

    stat_wr(2'b10);
    cfg_wr(0, 1, 0);
    cfg_wr(0, 0, 0);
    cfg_wr(1, 0, 0);
    tick_n(NS);
    expect_now("R2 long not at short limit", 0, 0, 0);
    tick_n(NL - NS - 1);
    expect_now("R2 long one tick early", 0, 0, 0);
    tick_n(1);
    expect_now("R2 long fires", 1, 0, 1);

    cfg_wr(0, 0, 0);
    stat_wr(2'b10);
    tick_n(NL + 5);
    expect_now("R1 disabled after clear", 0, 0, 0);

    lines(1, 0);
    lines(1, 1);
    expect_now("R7 stop ignored when ie=0", 0, 0, 0);
    cfg_wr(0, 0, 1);
    lines(1, 0);
    lines(1, 1);
    expect_now("R7 stop sets flag / R10", 0, 1, 1);
    stat_wr(2'b01);
    expect_now("R8 write 0 clears stop", 0, 0, 0);
    lines(0, 1);
    lines(0, 0);
    lines(0, 1);
    lines(1, 1);
    expect_now("R7 SDA rise with SCL low", 0, 0, 0);

    lines(1, 0);
    lines(1, 1);
    stat_wr(2'b11);
    expect_now("R8 write 1 keeps stop", 0, 1, 1);
    stat_wr(2'b01);
    lines(1, 0);
    @(negedge clk); clear_pulses();
    stat_we = 1'b1; stat_wdata = 2'b01; sda_in = 1'b1;
    expect_now("R9 set beats clear", 0, 1, 1);
    stat_wr(2'b01);
    expect_now("R8 final clear", 0, 0, 0);

    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  // Watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      total++;
      bad++;
      $display("FAIL watchdog: got cycles=%0d expected below 150000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule